// File: doc/BRIEF.md
# Local Countdown Interrupt Timer

This block is a 32-bit down-counter that raises an interrupt request at a programmed interval. Software writes three things through a shared write-data bus, each with its own strobe: a start value for the count, a divider setting for the clock prescaler, and a control word. The control word holds an 8-bit vector number, a mask flag and a mode flag. The current count is always visible on an output. Each time the count runs out, the block raises a one-cycle request that carries the vector.

The prescaler is a free-running counter of clock cycles. The divider setting selects a power-of-two divisor between 1 and 128. Writing the start value loads the count and also clears the prescaler, so the timing of every run is measured from that write. In one-shot mode the count stops at zero. In periodic mode it reloads the start value on the tick after zero. A start value of zero leaves the timer idle.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count reads 0 and no request is raised. The control word resets with the mask flag set, so no request is raised until an unmasked control word is written.
- R2: The divider setting is turned into a 3-bit code: bit 2 of the code is write-data bit 3, and bits 1:0 of the code are write-data bits 1:0. The prescaler shift is (code + 1) mod 8, and the count steps once every 2^shift clocks. Setting 0x0 divides by 2, 0x1 by 4, 0xA by 128, and 0xB by 1.
- R3: Only write-data bits 0, 1 and 3 of a divider write are kept. Bit 2 has no effect on the tick rate, so 0x4 acts as 0x0 and 0xF acts as 0xB.
- R4: A start-value write is visible on the count one clock after its edge. It also clears the prescaler, so the first decrement comes 2^shift clocks after that edge, whatever the prescaler held before.
- R5: In one-shot mode (control bit 17 = 0), the count drops by one per tick until it reaches 0, and then stays at 0.
- R6: In periodic mode (control bit 17 = 1), the tick that finds the count at 0 reloads the start value. With a start value N, a request is raised every N+1 ticks.
- R7: On the tick that takes the count from 1 to 0, the request output goes high for exactly one cycle, in the same cycle that the count first reads 0, and the vector output carries control bits 7:0. No request is raised if control bit 16 (the mask) is set.
- R8: With a start value of 0, the count stays at 0 and no request is raised in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 32 | Write data shared by all three write strobes |
| initWr | input | 1 | Loads the start value and count from wrData, and restarts the prescaler |
| divWr | input | 1 | Stores the divider setting from wrData bits 3, 1 and 0 |
| ctrlWr | input | 1 | Stores the vector (bits 7:0), mask (bit 16) and periodic mode (bit 17) |
| curCount | output | 32 | Present value of the count |
| fireValid | output | 1 | One-cycle interrupt request |
| fireVector | output | 8 | Vector of the latest request |

## Verification
A wrong prescaler phase or a wrong decoded shift shows up on curCount within at most 128 clocks. The first decrement arrives early or late, or the steps are spaced unevenly, so the count is checked on every cycle of each run against a closed-form value derived from the elapsed clocks. A fault in the reload or the hold at zero shows up one tick after the count first reads zero. A fault in the expiry detection shows up in the same cycle, as a missing or extra request or a wrong vector. The directed restart case puts the old prescaler phase one clock before a tick, so a prescaler that is not cleared gives a count that is one lower on the next clock.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // width of the prescaler shift amount; the largest shift sets the prescaler width
  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;

  // control-word flag positions
  localparam int MASK_POS = 16;
  localparam int PER_POS  = 17;

  // strobes from the control half to the count datapath
  typedef struct packed {
    logic load;      // take a new start value
    logic tick;      // prescaler rollover this cycle
    logic periodic;  // reload at zero instead of holding
  } cdtStrobe_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initWr,
  input  logic             divWr,
  input  logic [2:0]       divCode,
  input  logic             ctrlWr,
  input  logic [VEC_W-1:0] vecIn,
  input  logic             maskIn,
  input  logic             perIn,
  input  logic             cntZero,
  input  logic             cntOne,
  output cdtStrobe_t       strb,
  output logic             fireValid,
  output logic [VEC_W-1:0] fireVector
);
  logic [SHIFT_W-1:0] divKeep;
  logic [SHIFT_W-1:0] shiftAmt;
  logic [PRE_W-1:0]   preCnt;
  logic [PRE_W-1:0]   preMask;
  logic               tick;
  logic [VEC_W-1:0]   vecReg;
  logic               maskReg;
  logic               perReg;

  // divider setting: only the three meaningful bits are held
  always_ff @(posedge clk) begin
    if (!rstN)      divKeep <= '0;
    else if (divWr) divKeep <= divCode;
  end

  // shift = code + 1, wrapping so the top code means no division
  assign shiftAmt = divKeep + SHIFT_W'(1);
  assign preMask  = PRE_W'((32'd1 << shiftAmt) - 32'd1);

  // free-running prescaler, cleared by a start-value write
  always_ff @(posedge clk) begin
    if (!rstN)       preCnt <= '0;
    else if (initWr) preCnt <= '0;
    else             preCnt <= preCnt + PRE_W'(1);
  end

  assign tick = ((preCnt & preMask) == preMask);

  // control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReg  <= '0;
      maskReg <= 1'b1;
      perReg  <= 1'b0;
    end else if (ctrlWr) begin
      vecReg  <= vecIn;
      maskReg <= maskIn;
      perReg  <= perIn;
    end
  end

  always_comb begin
    strb.load     = initWr;
    strb.tick     = tick;
    strb.periodic = perReg;
  end

  // expiry request: the tick that moves the count from one to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fireValid  <= 1'b0;
      fireVector <= '0;
    end else begin
      fireValid <= tick && !initWr && cntOne && !maskReg;
      if (tick && !initWr && cntOne && !maskReg) fireVector <= vecReg;
    end
  end

  // a divided tick never lands on two neighbouring cycles
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && shiftAmt != '0 && !initWr && !divWr) |=> !tick);

  // a request coincides with the count reading zero
  assert_fire_at_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |-> cntZero);

  // a request lasts a single cycle
  assert_fire_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    fireValid |=> !fireValid);
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cdtStrobe_t       strb,
  input  logic [CNT_W-1:0] loadData,
  output logic [CNT_W-1:0] count,
  output logic             cntZero,
  output logic             cntOne
);
  logic [CNT_W-1:0] initReg;
  logic [CNT_W-1:0] cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initReg <= '0;
      cntReg  <= '0;
    end else if (strb.load) begin
      initReg <= loadData;
      cntReg  <= loadData;
    end else if (strb.tick) begin
      if (cntReg == '0) begin
        if (strb.periodic) cntReg <= initReg;
      end else begin
        cntReg <= cntReg - CNT_W'(1);
      end
    end
  end

  assign count   = cntReg;
  assign cntZero = (cntReg == '0);
  assign cntOne  = (cntReg == CNT_W'(1));

  assert_load_visible_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> count == $past(loadData));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && strb.tick && count != '0) |=> count == $past(count) - CNT_W'(1));

  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.periodic && count == '0) |=> count == '0);

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && strb.tick && strb.periodic && count == '0) |=> count == $past(initReg));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] wrData,
  input  logic             initWr,
  input  logic             divWr,
  input  logic             ctrlWr,
  output logic [CNT_W-1:0] curCount,
  output logic             fireValid,
  output logic [VEC_W-1:0] fireVector
);
  cdtStrobe_t strb;
  logic       cntZero;
  logic       cntOne;

  cdt_ctrl #(.VEC_W(VEC_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .initWr     (initWr),
    .divWr      (divWr),
    .divCode    ({wrData[3], wrData[1:0]}),
    .ctrlWr     (ctrlWr),
    .vecIn      (wrData[VEC_W-1:0]),
    .maskIn     (wrData[MASK_POS]),
    .perIn      (wrData[PER_POS]),
    .cntZero    (cntZero),
    .cntOne     (cntOne),
    .strb       (strb),
    .fireValid  (fireValid),
    .fireVector (fireVector)
  );

  cdt_datapath #(.CNT_W(CNT_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .loadData (wrData),
    .count    (curCount),
    .cntZero  (cntZero),
    .cntOne   (cntOne)
  );
endmodule

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wrData = '0;
  logic        initWr = 1'b0;
  logic        divWr = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [31:0] curCount;
  logic        fireValid;
  logic [7:0]  fireVector;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cdt_timer uut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .initWr(initWr), .divWr(divWr),
    .ctrlWr(ctrlWr), .curCount(curCount), .fireValid(fireValid), .fireVector(fireVector)
  );

  typedef struct packed {
    logic [31:0] initVal;
    logic [3:0]  divVal;
    logic [31:0] ctrlVal;
    logic [15:0] cycles;
    logic [7:0]  fires;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'd5,          4'hB, 32'h0000_0020, 16'd12,  8'd1},  // one-shot, divide by 1
    '{32'd3,          4'h0, 32'h0002_0041, 16'd20,  8'd2},  // periodic, divide by 2
    '{32'd2,          4'h1, 32'h0001_0033, 16'd16,  8'd0},  // masked one-shot
    '{32'd0,          4'hB, 32'h0002_0010, 16'd10,  8'd0},  // zero start, periodic
    '{32'd4,          4'hF, 32'h0002_007E, 16'd15,  8'd3},  // bit 2 ignored, divide by 1
    '{32'd1,          4'hA, 32'h0002_0099, 16'd300, 8'd1},  // divide by 128
    '{32'd6,          4'h4, 32'h0000_00C3, 16'd14,  8'd1},  // bit 2 ignored, divide by 2
    '{32'hFFFF_FFFF,  4'hB, 32'h0000_0005, 16'd8,   8'd0}   // full-width start
  };

  task automatic check(input string req, input string what, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic writeReg(input int sel, input logic [31:0] d);
    @(negedge clk);
    wrData = d;
    initWr = (sel == 0);
    divWr  = (sel == 1);
    ctrlWr = (sel == 2);
    @(posedge clk);
    @(negedge clk);
    initWr = 1'b0;
    divWr  = 1'b0;
    ctrlWr = 1'b0;
  endtask

  function automatic longint divisorOf(input logic [3:0] d);
    logic [2:0] code;
    logic [2:0] sh;
    code = {d[3], d[1:0]};
    sh   = code + 3'd1;
    return longint'(1) << sh;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "count after reset", curCount, 0);
    check("R1", "request after reset", fireValid, 0);

    // R1: the mask flag resets set, so an unprogrammed control word raises nothing
    begin
      int seen = 0;
      writeReg(0, 32'd2);
      for (int k = 0; k < 8; k++) begin
        @(posedge clk); @(negedge clk);
        if (fireValid) seen++;
      end
      check("R1", "requests with reset control word", seen, 0);
      check("R1", "count after reset-mask run", curCount, 0);
    end

    // table walk: R2 R3 R5 R6 R7 R8 and R4 load visibility
    for (int v = 0; v < 8; v++) begin
      longint n, d, t, expCnt;
      bit per, msk, expFire;
      int seen, cntErr, fireErr, vecErr;
      longint badGot, badExp;
      n   = longint'(TBL[v].initVal);
      d   = divisorOf(TBL[v].divVal);
      per = TBL[v].ctrlVal[17];
      msk = TBL[v].ctrlVal[16];
      writeReg(1, {28'd0, TBL[v].divVal});
      writeReg(2, TBL[v].ctrlVal);
      writeReg(0, TBL[v].initVal);
      check("R4", $sformatf("vector %0d count after start write", v), curCount, n);
      seen = 0; cntErr = 0; fireErr = 0; vecErr = 0; badGot = 0; badExp = 0;
      for (int k = 1; k <= int'(TBL[v].cycles); k++) begin
        @(posedge clk); @(negedge clk);
        t = k / d;
        if (per) expCnt = n - (t % (n + 1));
        else     expCnt = (t >= n) ? 0 : n - t;
        expFire = (k % d == 0) && (n != 0) && !msk &&
                  (per ? ((t % (n + 1)) == n) : (t == n));
        if (longint'(curCount) != expCnt && cntErr == 0) begin
          cntErr = 1; badGot = longint'(curCount); badExp = expCnt;
        end
        if (fireValid != expFire) fireErr++;
        if (fireValid) begin
          seen++;
          if (fireVector != TBL[v].ctrlVal[7:0]) vecErr++;
        end
      end
      check(per ? "R6" : "R5", $sformatf("vector %0d count trajectory (R2 R3)", v),
            cntErr ? badGot : expCnt, expCnt);
      check("R7", $sformatf("vector %0d request timing mismatches", v), fireErr, 0);
      check(n == 0 ? "R8" : "R7", $sformatf("vector %0d request count", v), seen, TBL[v].fires);
      check("R7", $sformatf("vector %0d wrong vectors", v), vecErr, 0);
    end

    // R4: a second start write clears the prescaler phase
    writeReg(1, 32'h0);
    writeReg(2, 32'h0000_0011);
    writeReg(0, 32'd10);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R4", "count before restart", curCount, 9);
    writeReg(0, 32'd5);
    check("R4", "count right after restart", curCount, 5);
    @(posedge clk); @(negedge clk);
    check("R4", "no decrement one clock after restart", curCount, 5);
    @(posedge clk); @(negedge clk);
    check("R4", "first decrement two clocks after restart", curCount, 4);

    // R6: periodic reload returns the count to the start value
    writeReg(1, 32'hB);
    writeReg(2, 32'h0002_0022);
    writeReg(0, 32'd2);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R7", "request as count reaches zero", fireValid, 1);
    check("R7", "vector of request", fireVector, 8'h22);
    @(posedge clk); @(negedge clk);
    check("R6", "reload after zero", curCount, 2);
    check("R7", "request drops after one cycle", fireValid, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule